// File: doc/BRIEF.md
# Flag-Producing ALU with Shifts

This block is a two-operand arithmetic and logic unit that computes `dest = dest op src` on 16-bit words. It covers addition and subtraction with and without an incoming carry, a flags-only compare, the four bitwise operations, and four single-bit moves: shift left, logical shift right, arithmetic shift right and rotate right through the carry. A byte-mode select restricts the whole operation, including every flag, to the low 8 bits of the operands. Subtraction is formed as `dest + NOT(src) + carry-in`, so after a subtract the carry flag means "no borrow". Shifts and the rotate move the bit that falls off the word into the carry flag.

An instruction sequencer presents one operation per cycle with `in_valid` high. Results and flags leave a registered output stage one cycle later. The output stage is a two-state machine. `ST_IDLE` means no operation was accepted on the previous edge. `ST_RESULT` means one was accepted and the outputs hold its effect. The transition named *accept* goes from either state to `ST_RESULT` when `in_valid` is high. The transition named *drain* goes from either state to `ST_IDLE` when `in_valid` is low. `wr_en` tells the register file to store `result`. It stays low for compare and for unassigned opcodes.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives `dest + src`. Opcode 1 (add with carry) gives `dest + src + carry_in`. For both, `flag_c` is the carry out of the operand MSB and `flag_v` is set when the signed two's complement sum is outside the operand range.
- R2: Opcode 2 (subtract) gives `dest + NOT(src) + 1`. Opcode 3 (subtract with carry) gives `dest + NOT(src) + carry_in`. `flag_c` is the carry out of that addition, which is 1 when no borrow occurs. `flag_v` is set when the signed difference (minus 1 when opcode 3 has `carry_in` = 0) is outside the range.
- R3: Opcode 4 (compare) sets `flag_c`, `flag_z`, `flag_n` and `flag_v` exactly as opcode 2 would. `wr_en` stays low and `result` keeps its previous value.
- R4: Opcode 5 is AND, opcode 6 is OR and opcode 7 is XOR, each of `dest` with `src` on every bit. Opcode 8 is the bitwise NOT of `dest`. For all four, `flag_v` is 0 and `flag_c` is 1 exactly when the result is non-zero.
- R5: Opcode 9 (shift left) fills the LSB with 0 and moves the old MSB into `flag_c`. Opcode 10 (logical shift right) fills the MSB with 0. Opcode 11 (arithmetic shift right) keeps the MSB. Opcodes 10 and 11 move the old LSB into `flag_c`. All three clear `flag_v`.
- R6: Opcode 12 (rotate right through carry) puts `carry_in` into the MSB and moves the old LSB into `flag_c`, with `flag_v` 0.
- R7: `flag_z` is 1 when the operation's value is zero. `flag_n` equals the operand-width MSB of that value.
- R8: With `byte_mode` = 1, operands, result, carry, overflow, zero and negative all use bits 7:0, and `result[15:8]` is 0.
- R9: `out_valid` is high in the cycle after `in_valid` was high and low otherwise. `wr_en` only pulses together with `out_valid`. When `in_valid` is low, `result` and all flags keep their values.
- R10: Opcodes 13 to 15 are unassigned. They leave `wr_en` low and keep `result` and all flags unchanged.
- R11: After reset, `out_valid`, `wr_en`, `result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code (see R1 to R6, R10) |
| byte_mode | input | 1 | 1 = operate on bits 7:0 only |
| dest | input | 16 | Destination operand |
| src | input | 16 | Source operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs reflect an accepted operation |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Store `result` into the destination |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
In byte mode, every value of `dest` is run through all thirteen operations against a shifting `src` pattern, with `carry_in` alternating. This separates carry-in handling from carry-out handling and exposes any leak of upper bits. In word mode, every pair drawn from a corner set (0, 1, 0x7FFF, 0x8000, 0xFFFF, 0x00FF, 0x5555, 0xAAAA) is run with both carry values. These pairs tell signed overflow apart from unsigned carry and arithmetic shifts apart from logical ones. A stretch of pseudo-random word operands follows. Idle cycles, compares and unassigned opcodes show whether held values are truly held.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_NOT = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_SAR = 4'd11,
        OP_RRC = 4'd12
    } alu_op_e;

    function automatic logic op_assigned(logic [OP_W-1:0] code);
        return code <= OP_RRC;
    endfunction

    function automatic logic op_is_logic(logic [OP_W-1:0] code);
        return (code == OP_AND) || (code == OP_OR) || (code == OP_XOR) || (code == OP_NOT);
    endfunction

endpackage

// File: rtl/alu_lane.sv
module alu_lane
    import flag_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout,
    output logic            ovf,
    output logic            writes
);

    logic          sub_like;
    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [W:0]    sum_full;
    logic          add_ovf;
    alu_op_e       op_e;

    assign op_e     = alu_op_e'(op);
    assign sub_like = (op_e == OP_SUB) || (op_e == OP_SBC) || (op_e == OP_CMP);
    assign b_eff    = sub_like ? ~b : b;

    always_comb begin
        unique case (op_e)
            OP_ADD:         c_eff = 1'b0;
            OP_SUB, OP_CMP: c_eff = 1'b1;
            default:        c_eff = cin;
        endcase
    end

    assign sum_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    assign add_ovf  = (a[W-1] == b_eff[W-1]) && (sum_full[W-1] != a[W-1]);

    always_comb begin
        res    = '0;
        cout   = 1'b0;
        ovf    = 1'b0;
        writes = 1'b1;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res  = sum_full[W-1:0];
                cout = sum_full[W];
                ovf  = add_ovf;
            end
            OP_CMP: begin
                res    = sum_full[W-1:0];
                cout   = sum_full[W];
                ovf    = add_ovf;
                writes = 1'b0;
            end
            OP_AND: begin
                res  = a & b;
                cout = |(a & b);
            end
            OP_OR: begin
                res  = a | b;
                cout = |(a | b);
            end
            OP_XOR: begin
                res  = a ^ b;
                cout = |(a ^ b);
            end
            OP_NOT: begin
                res  = ~a;
                cout = |(~a);
            end
            OP_SHL: begin
                res  = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            OP_SHR: begin
                res  = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            OP_SAR: begin
                res  = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            OP_RRC: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            default: begin
                writes = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              known,
    input  logic              writes,
    input  logic [DATA_W-1:0] nxt_res,
    input  logic              nxt_c,
    input  logic              nxt_z,
    input  logic              nxt_n,
    input  logic              nxt_v,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v
);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } stage_st_e;

    stage_st_e state_q;
    stage_st_e state_d;
    logic      wr_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            result <= '0;
            flag_c <= 1'b0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
            flag_v <= 1'b0;
        end else begin
            wr_q <= in_valid && writes;
            if (in_valid && writes) begin
                result <= nxt_res;
            end
            if (in_valid && known) begin
                flag_c <= nxt_c;
                flag_z <= nxt_z;
                flag_n <= nxt_n;
                flag_v <= nxt_v;
            end
        end
    end

    assign out_valid = (state_q == ST_RESULT);
    assign wr_en     = (state_q == ST_RESULT) && wr_q;

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en);

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_c) && $stable(flag_z)
                      && $stable(flag_n) && $stable(flag_v));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] dest,
    input  logic [DATA_W-1:0] src,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v
);

    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] word_res;
    logic              word_c;
    logic              word_v;
    logic              word_wr;
    logic [BYTE_W-1:0] byte_res;
    logic              byte_c;
    logic              byte_v;
    logic              byte_wr;

    logic [DATA_W-1:0] sel_res;
    logic              sel_c;
    logic              sel_v;
    logic              sel_wr;
    logic              sel_n;
    logic              sel_z;

    alu_lane #(.W(DATA_W)) u_word_lane (
        .op     (op),
        .a      (dest),
        .b      (src),
        .cin    (carry_in),
        .res    (word_res),
        .cout   (word_c),
        .ovf    (word_v),
        .writes (word_wr)
    );

    alu_lane #(.W(BYTE_W)) u_byte_lane (
        .op     (op),
        .a      (dest[BYTE_W-1:0]),
        .b      (src[BYTE_W-1:0]),
        .cin    (carry_in),
        .res    (byte_res),
        .cout   (byte_c),
        .ovf    (byte_v),
        .writes (byte_wr)
    );

    always_comb begin
        if (byte_mode) begin
            sel_res = {{HI_W{1'b0}}, byte_res};
            sel_c   = byte_c;
            sel_v   = byte_v;
            sel_wr  = byte_wr;
            sel_n   = byte_res[BYTE_W-1];
        end else begin
            sel_res = word_res;
            sel_c   = word_c;
            sel_v   = word_v;
            sel_wr  = word_wr;
            sel_n   = word_res[DATA_W-1];
        end
    end

    assign sel_z = (sel_res == '0);

    alu_out_stage #(.DATA_W(DATA_W)) u_out_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .known     (op_assigned(op)),
        .writes    (sel_wr),
        .nxt_res   (sel_res),
        .nxt_c     (sel_c),
        .nxt_z     (sel_z),
        .nxt_n     (sel_n),
        .nxt_v     (sel_v),
        .out_valid (out_valid),
        .wr_en     (wr_en),
        .result    (result),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_v    (flag_v)
    );

    p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=> !wr_en && $stable(result));

    p_logic_v_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_logic(op)) |=> !flag_v);

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_assigned(op) && op != OP_CMP) |=> (flag_z == (result == '0)));

    p_byte_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode && op_assigned(op) && op != OP_CMP)
        |=> (result[DATA_W-1:BYTE_W] == '0));

    p_unassigned_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_assigned(op)) |=> !wr_en && $stable(result) && $stable(flag_c)
                                            && $stable(flag_z) && $stable(flag_v));

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] dest = 16'd0;
    logic [15:0] src = 16'd0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [15:0] result;
    logic        wr_en;
    logic        flag_c, flag_z, flag_n, flag_v;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_res = 16'd0;
    logic        exp_c = 1'b0, exp_z = 1'b0, exp_n = 1'b0, exp_v = 1'b0, exp_wr = 1'b0;

    flag_alu i_flag_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
        .dest(dest), .src(src), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] code);
        if (code <= 4'd1) return "R1";
        if (code <= 4'd3) return "R2";
        if (code == 4'd4) return "R3";
        if (code <= 4'd8) return "R4";
        if (code <= 4'd11) return "R5";
        if (code == 4'd12) return "R6";
        return "R10";
    endfunction

    task automatic model(input logic [3:0] code, input logic bm, input logic [15:0] d,
                         input logic [15:0] s, input logic ci);
        int w, mask, a, b, sa, sb, t, half, r, c, v;
        w = bm ? 8 : 16;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        a = int'(d) & mask;
        b = int'(s) & mask;
        sa = (a >= half) ? a - (1 << w) : a;
        sb = (b >= half) ? b - (1 << w) : b;
        r = 0; c = 0; v = 0;
        case (code)
            4'd0, 4'd1: begin
                t = a + b + ((code == 4'd1) ? int'(ci) : 0);
                r = t & mask; c = (t >> w) & 1;
                t = sa + sb + ((code == 4'd1) ? int'(ci) : 0);
                v = (t >= half || t < -half) ? 1 : 0;
            end
            4'd2, 4'd3, 4'd4: begin
                t = a + ((~b) & mask) + ((code == 4'd3) ? int'(ci) : 1);
                r = t & mask; c = (t >> w) & 1;
                t = sa - sb - ((code == 4'd3) ? 1 - int'(ci) : 0);
                v = (t >= half || t < -half) ? 1 : 0;
            end
            4'd5: r = a & b;
            4'd6: r = a | b;
            4'd7: r = a ^ b;
            4'd8: r = (~a) & mask;
            4'd9:  begin r = (a << 1) & mask; c = (a >> (w - 1)) & 1; end
            4'd10: begin r = a >> 1; c = a & 1; end
            4'd11: begin r = (a >> 1) | (a & half); c = a & 1; end
            4'd12: begin r = (a >> 1) | (ci ? half : 0); c = a & 1; end
            default: ;
        endcase
        if (code >= 4'd5 && code <= 4'd8) c = (r != 0) ? 1 : 0;
        if (code <= 4'd12) begin
            exp_c = c[0]; exp_v = v[0];
            exp_z = (r == 0); exp_n = r[w-1];
            if (code != 4'd4) exp_res = r[15:0];
            exp_wr = (code != 4'd4);
        end else begin
            exp_wr = 1'b0;
        end
    endtask

    task automatic run_op(input logic [3:0] code, input logic bm, input logic [15:0] d,
                          input logic [15:0] s, input logic ci);
        string rq;
        in_valid = 1'b1; op = code; byte_mode = bm; dest = d; src = s; carry_in = ci;
        model(code, bm, d, s, ci);
        @(negedge clk);
        in_valid = 1'b0;
        rq = req_of(code);
        check({rq, " result/wr/c/v"}, {result, wr_en, flag_c, flag_v}, {exp_res, exp_wr, exp_c, exp_v});
        check("R7 zero/negative", {flag_z, flag_n}, {exp_z, exp_n});
        check("R9 out_valid after accept", out_valid, 1'b1);
        if (bm && code <= 4'd12 && code != 4'd4) check("R8 upper byte zero", result[15:8], 8'h00);
    endtask

    task automatic idle_cycle(input logic [15:0] d);
        in_valid = 1'b0; op = 4'd0; dest = d; src = ~d; carry_in = 1'b1;
        @(negedge clk);
        check("R9 idle holds", {out_valid, wr_en, result, flag_c, flag_z, flag_n, flag_v},
              {1'b0, 1'b0, exp_res, exp_c, exp_z, exp_n, exp_v});
    endtask

    logic [15:0] corners [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                 16'hFFFF, 16'h00FF, 16'h5555, 16'hAAAA};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {out_valid, wr_en, result, flag_c, flag_z, flag_n, flag_v}, 22'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", {out_valid, wr_en}, 2'b00);

        for (int code = 0; code < 13; code++) begin
            for (int a = 0; a < 256; a++) begin
                run_op(code[3:0], 1'b1, 16'hA500 | 16'(a), 16'h3C00 | 16'((a * 37 + 11) & 255),
                       a[0]);
            end
            idle_cycle(16'h1234);
        end

        for (int code = 0; code < 13; code++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int ci = 0; ci < 2; ci++)
                        run_op(code[3:0], 1'b0, corners[i], corners[j], ci[0]);

        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] d2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d2 = lfsr ^ 16'h9E37;
            run_op(4'(k % 16), k[4], lfsr, {d2[7:0], d2[15:8]}, k[1]);
            if (k % 97 == 0) idle_cycle(lfsr);
        end

        run_op(4'd0, 1'b0, 16'h1234, 16'h1111, 1'b0);
        run_op(4'd4, 1'b0, 16'h0005, 16'h0005, 1'b0);
        check("R3 compare equal sets Z keeps result", {flag_z, flag_c, result, wr_en},
              {1'b1, 1'b1, 16'h2345, 1'b0});
        run_op(4'd14, 1'b0, 16'h0000, 16'h0000, 1'b1);
        check("R10 unassigned keeps state", {result, flag_z, wr_en}, {16'h2345, 1'b1, 1'b0});
        run_op(4'd12, 1'b0, 16'h0002, 16'h0000, 1'b1);
        check("R6 rotate carry into MSB", {result, flag_c}, {16'h8001, 1'b0});
        run_op(4'd11, 1'b1, 16'hFF81, 16'h0000, 1'b0);
        check("R5 R8 byte arithmetic shift", {result, flag_c, flag_n}, {16'h00C0, 1'b1, 1'b1});
        run_op(4'd0, 1'b0, 16'h7FFF, 16'h0001, 1'b0);
        check("R1 signed overflow", {result, flag_v, flag_c}, {16'h8000, 1'b1, 1'b0});
        run_op(4'd2, 1'b0, 16'h0000, 16'h0001, 1'b0);
        check("R2 borrow clears carry", {result, flag_c, flag_v}, {16'hFFFF, 1'b0, 1'b0});
        idle_cycle(16'h0F0F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule